// File: doc/BRIEF.md
# Voltage Regulator Power Sequencer

This block is the digital sequencer of a processor core regulator. It leaves the off state when the supply is healthy and the enable input rises. After a short settling delay it commands a ramp to a fixed boot plateau. Once the sensed output has held above 1 V for a filter window, it releases the system clock, and the ramp target then follows the 7-bit voltage code. After a long settle time it declares power good.

While power is good, two power-state pins choose between two-phase continuous conduction, single-phase continuous conduction and single-phase light-load operation. Entering the deep-sleep state opens a fault-blanking window for the protection logic. When enable drops, the block ramps the target down at the slow rate. Once the sensed output is near zero, it parks the drivers in high impedance and enables the output discharge path.

The analog ramp itself lies outside the block. The block only issues the target code and selects one of two slew rates, where the fast rate is nominally five times the slow one. All delays are counted in clock cycles, computed from the clock-frequency parameter.

Top module: `vr_pwr_seq`

## Requirements
- R1: While `supply_ok` is low, from the next clock onward: `tgt_code`=0, `slew_fast`=0, `clk_en_n`=1, `pwr_good`=0, `ph2_en`=0, `light_load`=0, `drv_hiz`=1, `dischg_en`=0 and `flt_mask`=0. These are also the outputs after reset.
- R2: A start needs `en` to be seen low and then high while `supply_ok` is high. If `en` is already high when the supply returns, nothing happens. The boot plateau begins START_CYC+1 clock edges after `en` rises. During the boot plateau: `tgt_code`=88 (1.1 V), `slew_fast`=0 and `drv_hiz`=0.
- R3: During boot, `clk_en_n` falls after `sense_code` has been above 80 (1 V) for FILT_CYC consecutive edges. Any sample at or below 80 restarts this count. On the same edge, `tgt_code` switches to the voltage code.
- R4: `pwr_good` rises PG_CYC edges after `clk_en_n` falls, and it is never high while `clk_en_n` is high.
- R5: While `pwr_good` is high, the pins are decoded as follows. `pstate_deep`=1 gives `light_load`=1 and `ph2_en`=0. `pstate_deep`=0 with `pstate_full`=1 gives `ph2_en`=1 and `light_load`=0. Both pins at 0 give `ph2_en`=0 and `light_load`=0.
- R6: Before `pwr_good`, the power-state pins are ignored. `ph2_en` is 1 (unless R11 applies) and `light_load` is 0 in both the boot state and the clock-release state.
- R7: A rising `pstate_deep` while `pwr_good` is high raises `flt_mask` at the next edge and holds it for exactly FILT_CYC cycles.
- R8: `slew_fast` is 0 during boot and ramp-down. It is 1 from the clock release onward, including across power-state changes.
- R9: When `en` falls, the next edge gives `pwr_good`=0, `tgt_code`=0, `slew_fast`=0 and `clk_en_n`=1, with all enabled phases still on. Once `sense_code` is below 16 (200 mV), the next edge gives `drv_hiz`=1 and `dischg_en`=1.
- R10: The voltage code uses 12.5 mV per LSB, so codes 0..120 pass to `tgt_code` unchanged. Codes above 120 are clamped to 120 (1.5 V).
- R11: `strap_1ph` is sampled when a start is accepted. If it was 1, `ph2_en` stays 0 in every state until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Controller supply above its lockout threshold |
| en | input | 1 | Regulator enable |
| strap_1ph | input | 1 | Single-phase strap, sampled at start |
| vid | input | 7 | Voltage code, 12.5 mV per LSB |
| pstate_deep | input | 1 | Deep-sleep power-state pin |
| pstate_full | input | 1 | High-current power-state pin |
| sense_code | input | 8 | Sensed output voltage, 12.5 mV per LSB |
| tgt_code | output | 7 | Ramp target code, 12.5 mV per LSB |
| slew_fast | output | 1 | 1 selects the fast ramp rate |
| clk_en_n | output | 1 | Active-low clock enable |
| pwr_good | output | 1 | Power good |
| ph2_en | output | 1 | Phase 2 enable |
| light_load | output | 1 | Single-phase light-load mode select |
| drv_hiz | output | 1 | Gate drivers held off (high impedance) |
| dischg_en | output | 1 | Output discharge path enable |
| flt_mask | output | 1 | Protection blanking window |

## Verification
The hardest situations to reach lie deep in the sequence. One is a sensed-voltage dip in the middle of the 1 V filter window. The other is the deep-sleep blanking window, which only exists after the full power-good settle time. The bench shrinks the clock-frequency parameter so that every delay is a few thousand cycles at most. It drops `sense_code` to 1 V exactly once partway through the filter window and measures the restarted count edge by edge. It then raises the deep-sleep pin only after power good and counts the mask cycles. A second start, with the strap set, runs the whole sequence again to check that phase 2 stays off.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

    localparam int DAC_W = 7;
    localparam int SNS_W = 8;

    localparam logic [DAC_W-1:0] BOOT_CODE = 7'd88;
    localparam logic [DAC_W-1:0] DAC_TOP   = 7'd120;
    localparam logic [SNS_W-1:0] SNS_UP    = 8'd80;
    localparam logic [SNS_W-1:0] SNS_GONE  = 8'd16;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_BOOT,
        ST_CKREL,
        ST_RUN,
        ST_DOWN,
        ST_PARK
    } seq_st_t;

    typedef struct packed {
        logic ph2;
        logic lite;
    } phase_cfg_t;

    function automatic int ns_to_cyc(input int khz, input longint ns);
        longint c;
        c = (longint'(khz) * ns) / 64'd1000000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic [DAC_W-1:0] code_clamp(input logic [DAC_W-1:0] v);
        return (v > DAC_TOP) ? DAC_TOP : v;
    endfunction

endpackage

// File: rtl/vrs_fsm.sv
module vrs_fsm
    import vrs_pkg::*;
#(
    parameter int START_CYC = 1000,
    parameter int FILT_CYC  = 3650,
    parameter int PG_CYC    = 235000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic             en,
    input  logic             strap,
    input  logic [SNS_W-1:0] sense,
    output seq_st_t          st,
    output logic             strap_q
);

    localparam int MAXC = max3(START_CYC, FILT_CYC, PG_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic          en_q;
    logic          en_rise;

    assign en_rise = en & ~en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en;
    end

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            st      <= ST_OFF;
            cnt     <= '0;
            strap_q <= 1'b0;
        end else begin
            case (st)
                ST_OFF, ST_PARK: begin
                    cnt <= '0;
                    if (en_rise) begin
                        st      <= ST_WAIT;
                        strap_q <= strap;
                    end
                end
                ST_WAIT: begin
                    if (!en) begin
                        st  <= ST_OFF;
                        cnt <= '0;
                    end else if (cnt == CW'(START_CYC - 1)) begin
                        st  <= ST_BOOT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_BOOT: begin
                    if (!en) begin
                        st  <= ST_DOWN;
                        cnt <= '0;
                    end else if (sense > SNS_UP) begin
                        if (cnt == CW'(FILT_CYC - 1)) begin
                            st  <= ST_CKREL;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else begin
                        cnt <= '0;
                    end
                end
                ST_CKREL: begin
                    if (!en) begin
                        st  <= ST_DOWN;
                        cnt <= '0;
                    end else if (cnt == CW'(PG_CYC - 1)) begin
                        st  <= ST_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!en) st <= ST_DOWN;
                end
                ST_DOWN: begin
                    if (sense < SNS_GONE) st <= ST_PARK;
                end
                default: st <= ST_OFF;
            endcase
        end
    end

    // R2
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OFF && !en_rise) |=> st == ST_OFF);

    // R3
    filt_dip_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BOOT && sense <= SNS_UP) |=> st != ST_CKREL);

endmodule

// File: rtl/vrs_mode_dec.sv
module vrs_mode_dec
    import vrs_pkg::*;
(
    input  logic       all_ph,
    input  logic       run,
    input  logic       deep,
    input  logic       full,
    input  logic       one_ph,
    output phase_cfg_t cfg
);

    always_comb begin
        cfg = '0;
        if (all_ph) begin
            cfg.ph2 = ~one_ph;
        end else if (run) begin
            if (deep) begin
                cfg.lite = 1'b1;
            end else if (full) begin
                cfg.ph2 = ~one_ph;
            end
        end
    end

endmodule

// File: rtl/vrs_mask_gen.sv
module vrs_mask_gen #(
    parameter int WIN = 3650
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic arm,
    output logic mask
);

    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst || clr)        left <= '0;
        else if (arm)          left <= CW'(WIN);
        else if (left != '0)   left <= left - 1'b1;
    end

    assign mask = (left != '0);

    // R7
    mask_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (arm && !clr) |=> mask);

endmodule

// File: rtl/vr_pwr_seq.sv
module vr_pwr_seq
    import vrs_pkg::*;
#(
    parameter int CLK_KHZ = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       en,
    input  logic       strap_1ph,
    input  logic [6:0] vid,
    input  logic       pstate_deep,
    input  logic       pstate_full,
    input  logic [7:0] sense_code,
    output logic [6:0] tgt_code,
    output logic       slew_fast,
    output logic       clk_en_n,
    output logic       pwr_good,
    output logic       ph2_en,
    output logic       light_load,
    output logic       drv_hiz,
    output logic       dischg_en,
    output logic       flt_mask
);

    localparam int START_CYC = ns_to_cyc(CLK_KHZ, 64'd20000);
    localparam int FILT_CYC  = ns_to_cyc(CLK_KHZ, 64'd73000);
    localparam int PG_CYC    = ns_to_cyc(CLK_KHZ, 64'd4700000);

    seq_st_t    st;
    logic       strap_q;
    logic       deep_q;
    logic       is_run;
    logic       follow_vid;
    phase_cfg_t cfg;

    vrs_fsm #(
        .START_CYC (START_CYC),
        .FILT_CYC  (FILT_CYC),
        .PG_CYC    (PG_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .en        (en),
        .strap     (strap_1ph),
        .sense     (sense_code),
        .st        (st),
        .strap_q   (strap_q)
    );

    assign is_run     = (st == ST_RUN);
    assign follow_vid = (st == ST_CKREL) || is_run;

    vrs_mode_dec u_dec (
        .all_ph (st == ST_BOOT || st == ST_CKREL || st == ST_DOWN),
        .run    (is_run),
        .deep   (pstate_deep),
        .full   (pstate_full),
        .one_ph (strap_q),
        .cfg    (cfg)
    );

    always_ff @(posedge clk) begin
        if (rst) deep_q <= 1'b0;
        else     deep_q <= pstate_deep;
    end

    vrs_mask_gen #(
        .WIN (FILT_CYC)
    ) u_mask (
        .clk  (clk),
        .rst  (rst),
        .clr  (!supply_ok),
        .arm  (is_run && pstate_deep && !deep_q),
        .mask (flt_mask)
    );

    always_comb begin
        case (st)
            ST_BOOT:          tgt_code = BOOT_CODE;
            ST_CKREL, ST_RUN: tgt_code = code_clamp(vid);
            default:          tgt_code = '0;
        endcase
    end

    assign slew_fast  = follow_vid;
    assign clk_en_n   = ~follow_vid;
    assign pwr_good   = is_run;
    assign ph2_en     = cfg.ph2;
    assign light_load = cfg.lite;
    assign drv_hiz    = (st == ST_OFF) || (st == ST_WAIT) || (st == ST_PARK);
    assign dischg_en  = (st == ST_PARK);

    // R1
    supply_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (drv_hiz && !pwr_good && clk_en_n && !ph2_en && !light_load
                        && tgt_code == '0 && !dischg_en && !flt_mask && !slew_fast));

    // R4
    pg_after_clk_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_good |-> !clk_en_n);

    // R5
    lite_one_ph_chk: assert property (@(posedge clk) disable iff (rst)
        light_load |-> !ph2_en);

    // R9
    park_chk: assert property (@(posedge clk) disable iff (rst)
        dischg_en |-> (drv_hiz && tgt_code == '0));

    // R10
    tgt_range_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_code <= DAC_TOP);

    // R11
    strap_chk: assert property (@(posedge clk) disable iff (rst)
        strap_q |-> !ph2_en);

endmodule

// File: tb/test_vr_pwr_seq.sv
module test_vr_pwr_seq;

    localparam int KHZ = 1000;
    localparam int T_START = 20;
    localparam int T_FILT  = 73;
    localparam int T_PG    = 4700;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b0;
    logic       en = 1'b0;
    logic       strap_1ph = 1'b0;
    logic [6:0] vid = 7'd96;
    logic       pstate_deep = 1'b0;
    logic       pstate_full = 1'b1;
    logic [7:0] sense_code = 8'd0;
    logic [6:0] tgt_code;
    logic       slew_fast, clk_en_n, pwr_good, ph2_en, light_load;
    logic       drv_hiz, dischg_en, flt_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vr_pwr_seq #(.CLK_KHZ(KHZ)) i_vr_pwr_seq (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .en(en), .strap_1ph(strap_1ph),
        .vid(vid), .pstate_deep(pstate_deep), .pstate_full(pstate_full),
        .sense_code(sense_code), .tgt_code(tgt_code), .slew_fast(slew_fast),
        .clk_en_n(clk_en_n), .pwr_good(pwr_good), .ph2_en(ph2_en),
        .light_load(light_load), .drv_hiz(drv_hiz), .dischg_en(dischg_en),
        .flt_mask(flt_mask)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic off_outputs(input string req);
        chk(tgt_code == 0 && !slew_fast && clk_en_n && !pwr_good && !ph2_en && !light_load
            && drv_hiz && !dischg_en && !flt_mask, req,
            {tgt_code, slew_fast, clk_en_n, pwr_good, ph2_en, light_load, drv_hiz, dischg_en, flt_mask},
            {7'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
    endtask

    task automatic t_reset;
        step(3);
        rst = 1'b0;
        supply_ok = 1'b1;
        step(2);
        off_outputs("R1 reset state");
    endtask

    // start sequence up to power good; strap and pin tricks along the way
    task automatic t_bring_up(input bit strap);
        int n;
        strap_1ph = strap;
        pstate_deep = 1'b1;
        pstate_full = 1'b0;
        en = 1'b1;
        n = 0;
        do begin step(1); n++; end while (drv_hiz && n < 200);
        chk(n == T_START + 1, "R2 boot start delay", n, T_START + 1);
        chk(tgt_code == 7'd88 && !slew_fast, "R2 boot plateau", tgt_code, 88);
        chk(ph2_en == !strap && !light_load, "R6/R11 pins ignored in boot", ph2_en, !strap);
        sense_code = 8'd90;
        step(30);
        sense_code = 8'd80;
        step(1);
        sense_code = 8'd90;
        n = 0;
        do begin step(1); n++; end while (clk_en_n && n < 500);
        chk(n == T_FILT, "R3 filter restarted by dip", n, T_FILT);
        chk(tgt_code == vid, "R3 target follows code", tgt_code, vid);
        chk(slew_fast, "R8 fast after clock release", slew_fast, 1);
        chk(ph2_en == !strap && !light_load, "R6 pins ignored before power good", light_load, 0);
        n = 0;
        do begin step(1); n++; end while (!pwr_good && n < 6000);
        chk(n == T_PG, "R4 power good delay", n, T_PG);
        pstate_deep = 1'b0;
        pstate_full = 1'b1;
        step(1);
    endtask

    task automatic t_modes;
        int n;
        chk(ph2_en && !light_load, "R5 two-phase", ph2_en, 1);
        pstate_full = 1'b0;
        step(1);
        chk(!ph2_en && !light_load, "R5 single-phase", ph2_en, 0);
        chk(!flt_mask, "R7 no mask without deep rise", flt_mask, 0);
        pstate_deep = 1'b1;
        step(1);
        chk(light_load && !ph2_en, "R5 light load", light_load, 1);
        n = 0;
        while (flt_mask && n < 500) begin step(1); n++; end
        chk(n == T_FILT, "R7 mask window", n, T_FILT);
        pstate_full = 1'b1;
        pstate_deep = 1'b0;
        step(1);
        chk(ph2_en && !light_load && slew_fast, "R8 deep exit fast two-phase", ph2_en, 1);
    endtask

    task automatic t_vid;
        vid = 7'd100; step(1);
        chk(tgt_code == 7'd100, "R10 in-range code", tgt_code, 100);
        vid = 7'd127; step(1);
        chk(tgt_code == 7'd120, "R10 clamp", tgt_code, 120);
        vid = 7'd0; step(1);
        chk(tgt_code == 7'd0, "R10 zero code", tgt_code, 0);
        vid = 7'd96;
    endtask

    task automatic t_shutdown(input bit strap);
        en = 1'b0;
        step(1);
        chk(!pwr_good && tgt_code == 0 && !slew_fast && clk_en_n, "R9 ramp down", pwr_good, 0);
        chk(ph2_en == !strap && !drv_hiz, "R9 all phases during ramp down", ph2_en, !strap);
        sense_code = 8'd16;
        step(3);
        chk(!drv_hiz && !dischg_en, "R9 still driving at 16", drv_hiz, 0);
        sense_code = 8'd10;
        step(1);
        chk(drv_hiz && dischg_en, "R9 parked and discharging", dischg_en, 1);
    endtask

    task automatic t_supply;
        supply_ok = 1'b0;
        step(1);
        off_outputs("R1 supply loss");
        supply_ok = 1'b1;
        step(T_START + 10);
        chk(drv_hiz && tgt_code == 0, "R2 no start without enable edge", drv_hiz, 1);
        en = 1'b0;
        supply_ok = 1'b0;
        step(1);
        en = 1'b1;
        step(T_START + 10);
        chk(drv_hiz, "R2 no start with supply low", drv_hiz, 1);
    endtask

    initial begin
        t_reset();
        t_bring_up(1'b0);
        t_modes();
        t_vid();
        t_shutdown(1'b0);
        sense_code = 8'd0;
        step(2);
        t_bring_up(1'b1);
        chk(!ph2_en, "R11 strap holds phase 2 off in run", ph2_en, 0);
        t_shutdown(1'b1);
        sense_code = 8'd0;
        step(2);
        t_bring_up(1'b0);
        t_supply();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule